// File: doc/BRIEF.md
# Security-Banked Priority Register View

This block keeps the per-interrupt 8-bit priority levels, the priority mask, two binary point copies and two copies of the CPU-interface control word for one CPU interface. Every access carries a security flag. A secure access sees the raw stored values. A non-secure access sees a compressed view: priorities and the mask occupy only the upper half of the range, stored as `0x80 | (v >> 1)` and returned shifted left by one. Group-0 state is hidden from it, and it uses its own banked control and binary point copies.

The block sits between a register decoder and the arbitration logic. The decoder supplies a register select, an interrupt index, write data and read/write strobes. The group membership of each interrupt and the current running priority come from neighbouring logic as inputs. Read data is registered and appears one cycle after the read strobe, with a valid flag.

Top module: `prio_bank_view`

## Requirements
- R1: After reset, every priority, the priority mask, both control copies and both binary point copies are 0, and reads of them return 0.
- R2: A secure write to a priority (select 0) stores the low 8 bits unchanged. A secure read returns the stored value.
- R3: A non-secure write to the priority of a group-1 interrupt (`grp1_i[idx]=1`) stores `0x80 | (value >> 1)`.
- R4: A non-secure write to a group-0 priority leaves it unchanged. A non-secure read of a group-0 priority returns 0.
- R5: A non-secure read of a group-1 priority returns the stored value shifted left by one, truncated to 8 bits.
- R6: A secure write to the mask (select 1) stores the value raw. A non-secure mask write takes effect only while mask bit 7 is 1, and then stores `0x80 | (value >> 1)`.
- R7: A non-secure read of the mask, or of the running priority (select 5), returns the value shifted left by one and truncated to 8 bits when its bit 7 is 1, and 0 otherwise. A secure read returns the raw value.
- R8: A secure write to control (select 2) keeps bits [10:0] in the secure copy. A non-secure write keeps only bits 0, 5, 6 and 9 in the non-secure copy. Reads return the copy that matches the access's security state.
- R9: Secure control bit 1 and non-secure control bit 0 always hold the same value. A write to either copy updates the aliased bit of the other.
- R10: Binary point (select 3) is banked. A secure access uses the secure copy, a non-secure access uses the alias copy, and both keep the low 3 bits.
- R11: The aliased binary point (select 4) lets a secure access read and write the alias copy. A non-secure access to it reads 0, and its writes are ignored.
- R12: Read data is valid one cycle after `rd_en_i`. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| ns_i | input | 1 | 1 = non-secure access |
| sel_i | input | 3 | Register select: 0 priority, 1 mask, 2 control, 3 binary point, 4 aliased binary point, 5 running priority |
| idx_i | input | IDX_W (5) | Interrupt index for priority accesses |
| wdata_i | input | CTRL_W (11) | Write data |
| grp1_i | input | NUM_IRQ (32) | Per-interrupt group, 1 = group 1 |
| run_prio_i | input | 8 | Current running priority |
| rdata_o | output | CTRL_W (11) | Registered read data |
| rvalid_o | output | 1 | Read data valid |

## Verification
A read and a write can land on the same register in the same cycle. The read must return the value from before the write, and the write must still take effect. The bench provokes this by raising both strobes together on a priority entry and on the mask. The scoreboard expects the old value first. It then issues a plain read, which must return the new value. The control alias is a second kind of collision: one write updates both banks in the same cycle. The bench checks this by reading each bank after secure and after non-secure control writes.

// File: rtl/prio_view_pkg.sv
package prio_view_pkg;
  typedef enum logic [2:0] {
    SEL_PRIO  = 3'd0,
    SEL_PMASK = 3'd1,
    SEL_CTRL  = 3'd2,
    SEL_BPR   = 3'd3,
    SEL_ABPR  = 3'd4,
    SEL_RPRI  = 3'd5
  } reg_sel_e;

  localparam int unsigned PRIO_W = 8;

  // non-secure write into upper half
  function automatic logic [PRIO_W-1:0] ns_squeeze(input logic [PRIO_W-1:0] v);
    return {1'b1, v[PRIO_W-1:1]};
  endfunction

  // non-secure view: shifted when in upper half, else zero
  function automatic logic [PRIO_W-1:0] ns_upper_view(input logic [PRIO_W-1:0] v);
    return v[PRIO_W-1] ? {v[PRIO_W-2:0], 1'b0} : '0;
  endfunction
endpackage

// File: rtl/prio_store.sv
module prio_store
  import prio_view_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_IRQ)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              ns_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [PRIO_W-1:0] wdata_i,
  input  logic [NUM_IRQ-1:0] grp1_i,
  output logic [PRIO_W-1:0] view_o
);
  logic [PRIO_W-1:0] prio_q [NUM_IRQ];
  logic [PRIO_W-1:0] wval;
  logic              wallow;

  assign wallow = !ns_i || grp1_i[idx_i];
  assign wval   = ns_i ? ns_squeeze(wdata_i) : wdata_i;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 prio_q[g] <= '0;
      else if (we_i && wallow && idx_i == IDX_W'(g)) prio_q[g] <= wval;
    end
  end

  always_comb begin
    if (!ns_i)              view_o = prio_q[idx_i];
    else if (grp1_i[idx_i]) view_o = {prio_q[idx_i][PRIO_W-2:0], 1'b0};
    else                    view_o = '0;
  end

  p_ns_grp0_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ns_i && !grp1_i[idx_i]) |=> prio_q[$past(idx_i)] == $past(prio_q[idx_i]));

  p_ns_store_upper_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ns_i && grp1_i[idx_i]) |=> prio_q[$past(idx_i)][PRIO_W-1]);
endmodule

// File: rtl/iface_bank.sv
module iface_bank
  import prio_view_pkg::*;
#(
  parameter int unsigned CTRL_W = 11,
  parameter int unsigned BPR_W  = 3,
  parameter logic [CTRL_W-1:0] NS_KEEP = 11'h261
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              ns_i,
  input  reg_sel_e          sel_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [PRIO_W-1:0] pmask_o,
  output logic [CTRL_W-1:0] ctrl_s_o,
  output logic [CTRL_W-1:0] ctrl_ns_o,
  output logic [BPR_W-1:0]  bpr_s_o,
  output logic [BPR_W-1:0]  bpr_ns_o
);
  localparam int unsigned S_G1_BIT  = 1;
  localparam int unsigned NS_G1_BIT = 0;

  logic [PRIO_W-1:0] pmask_q;
  logic [CTRL_W-1:0] ctrl_s_q, ctrl_ns_q;
  logic [BPR_W-1:0]  bpr_s_q, bpr_ns_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pmask_q   <= '0;
      ctrl_s_q  <= '0;
      ctrl_ns_q <= '0;
      bpr_s_q   <= '0;
      bpr_ns_q  <= '0;
    end else if (we_i) begin
      unique case (sel_i)
        SEL_PMASK: begin
          if (!ns_i)                 pmask_q <= wdata_i[PRIO_W-1:0];
          else if (pmask_q[PRIO_W-1]) pmask_q <= ns_squeeze(wdata_i[PRIO_W-1:0]);
        end
        SEL_CTRL: begin
          if (!ns_i) begin
            ctrl_s_q             <= wdata_i;
            ctrl_ns_q[NS_G1_BIT] <= wdata_i[S_G1_BIT];
          end else begin
            ctrl_ns_q           <= wdata_i & NS_KEEP;
            ctrl_s_q[S_G1_BIT]  <= wdata_i[NS_G1_BIT];
          end
        end
        SEL_BPR: begin
          if (!ns_i) bpr_s_q  <= wdata_i[BPR_W-1:0];
          else       bpr_ns_q <= wdata_i[BPR_W-1:0];
        end
        SEL_ABPR: if (!ns_i) bpr_ns_q <= wdata_i[BPR_W-1:0];
        default: ;
      endcase
    end
  end

  assign pmask_o   = pmask_q;
  assign ctrl_s_o  = ctrl_s_q;
  assign ctrl_ns_o = ctrl_ns_q;
  assign bpr_s_o   = bpr_s_q;
  assign bpr_ns_o  = bpr_ns_q;

  p_mask_refused_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ns_i && sel_i == SEL_PMASK && !pmask_q[PRIO_W-1]) |=> $stable(pmask_q));

  p_grp1_alias_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_s_q[S_G1_BIT] == ctrl_ns_q[NS_G1_BIT]);

  p_ns_ctrl_bits_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_ns_q & ~NS_KEEP) == '0);

  p_abpr_ns_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ns_i && sel_i == SEL_ABPR) |=> $stable(bpr_ns_q));
endmodule

// File: rtl/prio_bank_view.sv
module prio_bank_view
  import prio_view_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned CTRL_W  = 11,
  parameter int unsigned BPR_W   = 3,
  localparam int unsigned IDX_W  = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_en_i,
  input  logic               wr_en_i,
  input  logic               ns_i,
  input  logic [2:0]         sel_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [CTRL_W-1:0]  wdata_i,
  input  logic [NUM_IRQ-1:0] grp1_i,
  input  logic [PRIO_W-1:0]  run_prio_i,
  output logic [CTRL_W-1:0]  rdata_o,
  output logic               rvalid_o
);
  reg_sel_e          sel;
  logic [PRIO_W-1:0] prio_view, pmask;
  logic [CTRL_W-1:0] ctrl_s, ctrl_ns, rmux;
  logic [BPR_W-1:0]  bpr_s, bpr_ns;

  assign sel = reg_sel_e'(sel_i);

  prio_store #(.NUM_IRQ(NUM_IRQ)) u_store (
    .clk_i, .rst_ni,
    .we_i    (wr_en_i && sel == SEL_PRIO),
    .ns_i,
    .idx_i,
    .wdata_i (wdata_i[PRIO_W-1:0]),
    .grp1_i,
    .view_o  (prio_view)
  );

  iface_bank #(.CTRL_W(CTRL_W), .BPR_W(BPR_W)) u_iface (
    .clk_i, .rst_ni,
    .we_i      (wr_en_i),
    .ns_i,
    .sel_i     (sel),
    .wdata_i,
    .pmask_o   (pmask),
    .ctrl_s_o  (ctrl_s),
    .ctrl_ns_o (ctrl_ns),
    .bpr_s_o   (bpr_s),
    .bpr_ns_o  (bpr_ns)
  );

  always_comb begin
    rmux = '0;
    unique case (sel)
      SEL_PRIO:  rmux = CTRL_W'(prio_view);
      SEL_PMASK: rmux = CTRL_W'(ns_i ? ns_upper_view(pmask) : pmask);
      SEL_CTRL:  rmux = ns_i ? ctrl_ns : ctrl_s;
      SEL_BPR:   rmux = CTRL_W'(ns_i ? bpr_ns : bpr_s);
      SEL_ABPR:  rmux = ns_i ? '0 : CTRL_W'(bpr_ns);
      SEL_RPRI:  rmux = CTRL_W'(ns_i ? ns_upper_view(run_prio_i) : run_prio_i);
      default:   rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rmux;
    end
  end

  p_rvalid_next_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);

  p_ns_abpr_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && ns_i && sel == SEL_ABPR) |=> rdata_o == '0);
endmodule

// File: tb/prio_bank_view_bench.sv
module prio_bank_view_bench;
  localparam int unsigned NUM_IRQ = 32;
  localparam int unsigned CTRL_W  = 11;
  localparam int unsigned IDX_W   = 5;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               rd_en = 1'b0, wr_en = 1'b0, ns = 1'b0;
  logic [2:0]         sel = '0;
  logic [IDX_W-1:0]   idx = '0;
  logic [CTRL_W-1:0]  wdata = '0;
  logic [NUM_IRQ-1:0] grp1 = 32'hFFFF_0000;
  logic [7:0]         run_prio = '0;
  logic [CTRL_W-1:0]  rdata;
  logic               rvalid;

  int checks = 0, fails = 0;
  logic [CTRL_W-1:0] exp_q[$];
  string             req_q[$];

  always #2 clk = ~clk;

  prio_bank_view u_prio_bank_view (
    .clk_i(clk), .rst_ni, .rd_en_i(rd_en), .wr_en_i(wr_en), .ns_i(ns),
    .sel_i(sel), .idx_i(idx), .wdata_i(wdata), .grp1_i(grp1),
    .run_prio_i(run_prio), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  // monitor
  always @(negedge clk) begin
    if (rst_ni && rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected read data %h, expected none", "R12", rdata);
      end else begin
        automatic logic [CTRL_W-1:0] e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s: got %h expected %h", r, rdata, e);
        end
      end
    end
  end

  // driver: called at a negedge
  task automatic op(input bit rd, input bit wr, input bit n, input logic [2:0] s,
                    input logic [IDX_W-1:0] i, input logic [CTRL_W-1:0] wd,
                    input logic [CTRL_W-1:0] e, input string r);
    rd_en = rd; wr_en = wr; ns = n; sel = s; idx = i; wdata = wd;
    if (rd) begin exp_q.push_back(e); req_q.push_back(r); end
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic wr(input bit n, input logic [2:0] s, input logic [IDX_W-1:0] i,
                    input logic [CTRL_W-1:0] wd);
    op(1'b0, 1'b1, n, s, i, wd, '0, "");
  endtask

  task automatic rd(input bit n, input logic [2:0] s, input logic [IDX_W-1:0] i,
                    input logic [CTRL_W-1:0] e, input string r);
    op(1'b1, 1'b0, n, s, i, '0, e, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(0, 3'd0, 5'd3,  '0, "R1");
    rd(0, 3'd0, 5'd20, '0, "R1");
    rd(0, 3'd1, 0, '0, "R1");
    rd(0, 3'd2, 0, '0, "R1");
    rd(1, 3'd2, 0, '0, "R1");
    rd(0, 3'd3, 0, '0, "R1");
    rd(0, 3'd4, 0, '0, "R1");
    // R2 secure priority
    wr(0, 3'd0, 5'd3, 11'h05A);
    rd(0, 3'd0, 5'd3, 11'h05A, "R2");
    // R4 group-0 hidden and protected
    rd(1, 3'd0, 5'd3, 11'h000, "R4");
    wr(1, 3'd0, 5'd3, 11'h0FF);
    rd(0, 3'd0, 5'd3, 11'h05A, "R4");
    // R3 / R5 group-1 non-secure
    wr(1, 3'd0, 5'd20, 11'h064);
    rd(0, 3'd0, 5'd20, 11'h0B2, "R3");
    rd(1, 3'd0, 5'd20, 11'h064, "R5");
    wr(0, 3'd0, 5'd21, 11'h0C1);
    rd(1, 3'd0, 5'd21, 11'h082, "R5");
    // R6 / R7 mask
    wr(1, 3'd1, 0, 11'h0FF);
    rd(0, 3'd1, 0, 11'h000, "R6");
    wr(0, 3'd1, 0, 11'h090);
    rd(0, 3'd1, 0, 11'h090, "R6");
    rd(1, 3'd1, 0, 11'h020, "R7");
    wr(1, 3'd1, 0, 11'h040);
    rd(0, 3'd1, 0, 11'h0A0, "R6");
    wr(0, 3'd1, 0, 11'h030);
    rd(1, 3'd1, 0, 11'h000, "R7");
    // R7 running priority
    run_prio = 8'hC4;
    rd(1, 3'd5, 0, 11'h088, "R7");
    rd(0, 3'd5, 0, 11'h0C4, "R7");
    run_prio = 8'h44;
    rd(1, 3'd5, 0, 11'h000, "R7");
    // R8 / R9 control banks
    wr(0, 3'd2, 0, 11'h7FF);
    rd(0, 3'd2, 0, 11'h7FF, "R8");
    rd(1, 3'd2, 0, 11'h001, "R9");
    wr(1, 3'd2, 0, 11'h7FE);
    rd(1, 3'd2, 0, 11'h260, "R8");
    rd(0, 3'd2, 0, 11'h7FD, "R9");
    wr(0, 3'd2, 0, 11'h002);
    rd(1, 3'd2, 0, 11'h261, "R9");
    // R10 / R11 binary point
    wr(0, 3'd3, 0, 11'h00D);
    wr(1, 3'd3, 0, 11'h00E);
    rd(0, 3'd3, 0, 11'h005, "R10");
    rd(1, 3'd3, 0, 11'h006, "R10");
    rd(0, 3'd4, 0, 11'h006, "R11");
    wr(1, 3'd4, 0, 11'h001);
    rd(0, 3'd4, 0, 11'h006, "R11");
    rd(1, 3'd4, 0, 11'h000, "R11");
    wr(0, 3'd4, 0, 11'h00F);
    rd(1, 3'd3, 0, 11'h007, "R11");
    // R12 read and write in one cycle
    op(1, 1, 0, 3'd0, 5'd5, 11'h033, 11'h000, "R12");
    rd(0, 3'd0, 5'd5, 11'h033, "R12");
    op(1, 1, 0, 3'd1, 0, 11'h077, 11'h030, "R12");
    rd(0, 3'd1, 0, 11'h077, "R12");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R12: %0d reads without data, expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule